// File: doc/BRIEF.md
# Line-Sync Triggered Beam and Modulation Pulse Timer

The block watches a mains-rate line-sync input. Each time that input goes high after being low, it runs one timed sequence and produces two pulses. The beam-enable pulse is long and has a fixed length. The modulation pulse sits inside it, and its width can be trimmed. All timing is counted in clock ticks. At the intended 16 MHz clock one tick is 62.5 ns.

A down-counter is loaded once at the start of each segment and holds that segment's length. The segment ends in the cycle the counter reads one. A 4-bit trim value sets the width of the modulation pulse. The trim is spread over two complementary segments: one counts the trim and the other counts its bit inverse. Because the two always add up to the same length, the beam pulse length does not depend on the trim.

The states and their transitions are as follows:
- ST_IDLE → ST_LEAD1 when the synchronized sync is high.
- ST_LEAD1 → ST_LEAD2 → ST_MODBASE → ST_MODTRIM → ST_TAILTRIM → ST_TAIL, each step taken when the current segment expires.
- ST_TAIL → ST_REARM when its segment expires.
- ST_REARM → ST_IDLE once the synchronized sync reads low.

Top module: `linesync_pulse_gen`

## Requirements
- R1: An active-low asynchronous reset forces the idle state and drives beam_o and mod_o low at once.
- R2: line_sync passes through two flops. beam_o rises on the third rising clock edge after line_sync is first sampled high.
- R3: beam_o stays high for exactly 5664 ticks (354 µs at 16 MHz) for every trim value 0 to 15.
- R4: mod_o rises exactly 4000 ticks (250 µs) after beam_o rises.
- R5: mod_o stays high for 1576 + 2×trim ticks, where trim is the unsigned value on trim_i. This gives 1576 ticks at trim 0, 1592 at trim 8 and 1606 at trim 15. Because the trim segment is loaded with bit 0 set, it lasts at least one tick even when trim is 0.
- R6: mod_o falls exactly 88 − 2×trim ticks before beam_o falls. This gap is the inverse-trim segment of 2×(15−trim)+1 ticks followed by a fixed 57-tick tail.
- R7: While line_sync stays high after a sequence ends, beam_o stays low. A new sequence starts only after line_sync has been seen low and then high again.
- R8: line_sync going low during a sequence does not shorten or abort it.
- R9: mod_o is never high while beam_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, one tick per cycle |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_sync | input | 1 | Mains-rate sync, asynchronous to clk |
| trim_i | input | 4 | Modulation width trim, unsigned |
| beam_o | output | 1 | Beam-enable pulse |
| mod_o | output | 1 | Modulation pulse |

## Verification
Two events can fall in the same cycle: the last tick of the final tail segment, and the arrival of a synchronized low on line_sync that re-arms the block. The bench holds line_sync high for a sweep of lengths around the sequence length, so that the falling edge lands just before, on, and just after the cycle the tail expires. It then raises line_sync again. In every case the following sequence must start exactly three edges after the new rise, with all of its segment timings intact.

// File: rtl/lsp_pkg.sv
package lsp_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD1,
        ST_LEAD2,
        ST_MODBASE,
        ST_MODTRIM,
        ST_TAILTRIM,
        ST_TAIL,
        ST_REARM
    } lsp_state_e;
endpackage

// File: rtl/lsp_sync.sv
module lsp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain[g] <= 1'b0;
                end else if (g == 0) begin
                    chain[g] <= d_i;
                end else begin
                    chain[g] <= chain[(g == 0) ? 0 : g-1];
                end
            end
        end
    endgenerate

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/lsp_counter.sv
module lsp_counter #(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             last_o
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load_i) begin
            cnt <= load_val_i;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign last_o = (cnt == CNT_W'(1));

    // R5: a load is never zero, so every segment lasts at least one tick
    a_r5_load_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (cnt != '0));

    // R3: between loads the count steps down by exactly one
    a_r3_steady_count: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && cnt > CNT_W'(1)) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/lsp_fsm.sv
module lsp_fsm
    import lsp_pkg::*;
#(
    parameter int CNT_W          = 11,
    parameter int TRIM_W         = 4,
    parameter int LEAD_TICKS     = 2000,
    parameter int MODBASE_TICKS  = 1575,
    parameter int TAIL_TICKS     = 57
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_i,
    input  logic              last_i,
    input  logic [TRIM_W-1:0] trim_i,
    output logic              load_o,
    output logic [CNT_W-1:0]  load_val_o,
    output logic              beam_o,
    output logic              mod_o
);
    localparam int PAD_W = CNT_W - TRIM_W - 1;
    localparam logic [CNT_W-1:0] L_LEAD    = CNT_W'(LEAD_TICKS);
    localparam logic [CNT_W-1:0] L_MODBASE = CNT_W'(MODBASE_TICKS);
    localparam logic [CNT_W-1:0] L_TAIL    = CNT_W'(TAIL_TICKS);

    lsp_state_e state, nxt;
    logic [CNT_W-1:0] trim_val, inv_val;

    assign trim_val = {{PAD_W{1'b0}}, trim_i, 1'b1};
    assign inv_val  = {{PAD_W{1'b0}}, ~trim_i, 1'b1};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    always_comb begin
        nxt        = state;
        load_o     = 1'b0;
        load_val_o = L_LEAD;
        unique case (state)
            ST_IDLE: if (sync_i) begin
                nxt = ST_LEAD1; load_o = 1'b1; load_val_o = L_LEAD;
            end
            ST_LEAD1: if (last_i) begin
                nxt = ST_LEAD2; load_o = 1'b1; load_val_o = L_LEAD;
            end
            ST_LEAD2: if (last_i) begin
                nxt = ST_MODBASE; load_o = 1'b1; load_val_o = L_MODBASE;
            end
            ST_MODBASE: if (last_i) begin
                nxt = ST_MODTRIM; load_o = 1'b1; load_val_o = trim_val;
            end
            ST_MODTRIM: if (last_i) begin
                nxt = ST_TAILTRIM; load_o = 1'b1; load_val_o = inv_val;
            end
            ST_TAILTRIM: if (last_i) begin
                nxt = ST_TAIL; load_o = 1'b1; load_val_o = L_TAIL;
            end
            ST_TAIL: if (last_i) begin
                nxt = ST_REARM;
            end
            ST_REARM: if (!sync_i) begin
                nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        beam_o = (state != ST_IDLE) && (state != ST_REARM);
        mod_o  = (state == ST_MODBASE) || (state == ST_MODTRIM);
    end

    // R2: a sequence only opens on a synchronized high sync
    a_r2_start_on_sync: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(beam_o) |-> $past(sync_i));

    // R7: re-arming requires the synchronized sync to be low
    a_r7_rearm_low: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_REARM && sync_i) |=> (state == ST_REARM));
endmodule

// File: rtl/linesync_pulse_gen.sv
module linesync_pulse_gen #(
    parameter int CNT_W         = 11,
    parameter int TRIM_W        = 4,
    parameter int SYNC_STAGES   = 2,
    parameter int LEAD_TICKS    = 2000,
    parameter int MODBASE_TICKS = 1575,
    parameter int TAIL_TICKS    = 57
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_sync,
    input  logic [TRIM_W-1:0] trim_i,
    output logic              beam_o,
    output logic              mod_o
);
    logic             sync_s;
    logic             seg_last;
    logic             seg_load;
    logic [CNT_W-1:0] seg_val;

    lsp_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (line_sync),
        .q_o   (sync_s)
    );

    lsp_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (seg_load),
        .load_val_i (seg_val),
        .last_o     (seg_last)
    );

    lsp_fsm #(
        .CNT_W         (CNT_W),
        .TRIM_W        (TRIM_W),
        .LEAD_TICKS    (LEAD_TICKS),
        .MODBASE_TICKS (MODBASE_TICKS),
        .TAIL_TICKS    (TAIL_TICKS)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .sync_i     (sync_s),
        .last_i     (seg_last),
        .trim_i     (trim_i),
        .load_o     (seg_load),
        .load_val_o (seg_val),
        .beam_o     (beam_o),
        .mod_o      (mod_o)
    );

    // R9: modulation only inside the beam pulse
    a_r9_mod_in_beam: assert property (@(posedge clk) disable iff (!rst_n)
        mod_o |-> beam_o);

    // R4: modulation rises only after beam has already been high
    a_r4_mod_after_beam: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mod_o) |-> $past(beam_o));

    // R6: modulation ends while beam is still high
    a_r6_mod_ends_first: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mod_o) |-> beam_o);

    // R7: beam stays low for at least one cycle after it falls
    a_r7_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(beam_o) |=> !beam_o);
endmodule

// File: tb/linesync_pulse_gen_bench.sv
module linesync_pulse_gen_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line_sync = 1'b0;
    logic [3:0] trim_i = 4'd8;
    logic       beam_o, mod_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int n_done = 0;

    int q_sync[$];
    int q_trim[$];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    linesync_pulse_gen u_linesync_pulse_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_sync (line_sync),
        .trim_i    (trim_i),
        .beam_o    (beam_o),
        .mod_o     (mod_o)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // monitor: measures pulse edges and compares with scoreboard items
    logic pb = 1'b0, pm = 1'b0;
    int t_br = 0, t_mr = 0, t_mf = 0;
    always @(negedge clk) begin
        if (!rst_n) begin
            pb = 1'b0; pm = 1'b0;
        end else begin
            if (beam_o && !pb) t_br = cyc;
            if (mod_o && !pm) t_mr = cyc;
            if (!mod_o && pm) t_mf = cyc;
            if (!beam_o && pb) begin
                if (q_sync.size() == 0) begin
                    check("R7 unexpected pulse", 1, 0);
                end else begin
                    int s, t;
                    s = q_sync.pop_front();
                    t = q_trim.pop_front();
                    check("R2 start delay", t_br - s, 3);
                    check("R4 mod offset", t_mr - t_br, 4000);
                    check("R5 mod width", t_mf - t_mr, 1576 + 2*t);
                    check("R6 tail gap", cyc - t_mf, 88 - 2*t);
                    check("R3 beam width", cyc - t_br, 5664);
                end
                n_done++;
            end
            pb = beam_o; pm = mod_o;
        end
    end

    // driver: raise sync, hold for hi cycles, expect one full pulse
    task automatic pulse(input int trim, input int hi, input int lo);
        int target;
        @(negedge clk);
        trim_i = 4'(trim);
        line_sync = 1'b1;
        q_sync.push_back(cyc);
        q_trim.push_back(trim);
        target = n_done + 1;
        repeat (hi) @(negedge clk);
        line_sync = 1'b0;
        while (n_done < target) @(negedge clk);
        repeat (lo) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual %0d expected 0", cyc);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        line_sync = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 beam in reset", int'(beam_o), 0);
        check("R1 mod in reset", int'(mod_o), 0);
        line_sync = 1'b0;
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check("R1 beam idle", int'(beam_o), 0);

        // R3 R5 R6: several trims incl. both ends, R8 short sync
        pulse(8, 10, 10);
        pulse(0, 10, 10);
        pulse(15, 10, 10);
        pulse(5, 100, 10);
        pulse(12, 2, 10);

        // R7: hold sync far past the sequence; no retrigger
        begin
            int rises;
            rises = 0;
            @(negedge clk);
            trim_i = 4'd3;
            line_sync = 1'b1;
            q_sync.push_back(cyc);
            q_trim.push_back(3);
            while (n_done < 6) @(negedge clk);
            for (int i = 0; i < 2000; i++) begin
                @(negedge clk);
                if (beam_o) rises++;
            end
            check("R7 no retrigger while high", rises, 0);
            line_sync = 1'b0;
            repeat (10) @(negedge clk);
        end

        // coincidence sweep: sync low lands around the tail expiry
        for (int h = 5662; h <= 5670; h++) begin
            pulse(h % 16, h, 20);
        end

        // R1: reset mid-sequence drops outputs at once
        @(negedge clk);
        trim_i = 4'd7;
        line_sync = 1'b1;
        repeat (4500) @(negedge clk);
        check("R1 mod before reset", int'(mod_o), 1);
        rst_n = 1'b0;
        #1;
        check("R1 beam async reset", int'(beam_o), 0);
        check("R1 mod async reset", int'(mod_o), 0);
        line_sync = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check("R1 idle after reset", int'(beam_o), 0);
        pulse(9, 10, 10);
        check("R3 scoreboard drained", q_sync.size(), 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule